// File: doc/BRIEF.md
# PHY PLL bring-up sequencer

This block drives the control inputs of a display PHY's PLL through a fixed power-up order. It is given divider and loop settings that were already computed, plus the configuration clock rate in MHz. On a start pulse it captures them. It then selects the generated clock, pulses the shadow-clear control and loads three packed control words. After that it enables the reference clock, waits for the reference clock to settle, and raises the update control for a minimum width. A one-cycle done pulse marks the end of the sequence.

A stop pulse can arrive at any point. It returns all three control words to zero, drops the reference-clock enable and abandons any sequence in progress. Every wait is a parameter counted in system-clock cycles. The defaults suit a 100 MHz clock: 100 cycles between steps, and 1000 cycles each for the settle wait and the update pulse.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, all three control words, the reference enable, busy and done are zero.
- R2: A start pulse while idle sets busy. In the next cycle the main word equals 0x40, which is the clock-select field [7:6] = 1 with every other bit zero. It holds that value for STEP_CYC cycles.
- R3: The main word then becomes 0x40 with bit 18 (shadow clear) set, for STEP_CYC cycles. It then returns to 0x40 for another STEP_CYC cycles.
- R4: Next, the main word is loaded with clock select in [7:6] = 1, the HS range value in [14:8], and ((cfg MHz − 17) × 4) mod 64 in [5:0].
- R5: In the same cycle, word 0 is loaded with (M − 2) mod 1024 in [9:0], (N − 1) mod 16 in [13:10], VCO control in [19:14], proportional control in [25:20], and zero in [31:26].
- R6: In the same cycle, word 1 is loaded with 0x41, which is field [1:0] = 1 and bias field [8:2] = 0x10.
- R7: The reference enable rises one cycle after the words load. Bit 17 (update) of the main word is set SETTLE_CYC cycles later.
- R8: Update stays high for exactly UPD_CYC cycles. In the cycle it clears, done is high for that single cycle and busy drops.
- R9: A start pulse while busy is ignored, and the sequence and the captured values are unchanged.
- R10: A stop pulse takes priority over start. In the next cycle all words, the reference enable, busy and done are zero.
- R11: After done, the words and the reference enable hold their values, with update clear, until stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the bring-up sequence |
| stop_i | input | 1 | Zero all controls and abort |
| m_i | input | 11 | Feedback multiplier M |
| n_i | input | 5 | Input divider N |
| vco_i | input | 6 | VCO control value |
| prop_i | input | 6 | Proportional loop control value |
| hsr_i | input | 7 | HS frequency range code |
| cfg_mhz_i | input | 8 | Configuration clock rate in MHz |
| ctrl_main_o | output | 32 | Main control word (clock select, shadow clear, update, ranges) |
| ctrl_w0_o | output | 32 | Divider and loop control word |
| ctrl_w1_o | output | 32 | Charge-pump control word |
| ref_en_o | output | 1 | Reference clock enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence end |

## Verification
The bench builds the block with STEP_CYC = 2, SETTLE_CYC = 10 and UPD_CYC = 4. With these values a whole sequence takes 21 cycles, so the bench can compare every cycle of it against a timeline worked out arithmetically. It can also issue stop at each of those cycles in turn. The short timeline allows sixteen sets of settings to be swept through the word packing, including the M and N offset wrap limits and every config-clock value from 17 to 32 MHz.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int WORD_W  = 32;
  localparam int M_W     = 11;
  localparam int N_W     = 5;
  localparam int VCO_W   = 6;
  localparam int PROP_W  = 6;
  localparam int HSR_W   = 7;
  localparam int CFG_W   = 8;

  // main word layout
  localparam int CFGR_LSB   = 0;
  localparam int CFGR_W     = 6;
  localparam int CSEL_LSB   = 6;
  localparam int HSR_LSB    = 8;
  localparam int UPD_BIT    = 17;
  localparam int SHCLR_BIT  = 18;
  localparam logic [1:0] CSEL_GEN = 2'd1;

  // word 0 layout
  localparam int MOFF_W    = 10;
  localparam int NOFF_LSB  = 10;
  localparam int NOFF_W    = 4;
  localparam int VCO_LSB   = 14;
  localparam int PROP_LSB  = 20;

  // word 1 layout
  localparam logic [1:0] GMP_VAL    = 2'd1;
  localparam int         BIAS_LSB   = 2;
  localparam logic [6:0] BIAS_VAL   = 7'h10;

  localparam int CFG_BASE_MHZ = 17;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSEL,
    ST_SHCLR,
    ST_REL,
    ST_LOAD,
    ST_SETTLE,
    ST_UPD
  } seq_state_t;
endpackage

// File: rtl/pll_wait_timer.sv
module pll_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_seq_pkg::*;
(
  input  logic [M_W-1:0]    m,
  input  logic [N_W-1:0]    n,
  input  logic [VCO_W-1:0]  vco,
  input  logic [PROP_W-1:0] prop,
  input  logic [HSR_W-1:0]  hsr,
  input  logic [CFG_W-1:0]  cfg_mhz,
  output logic [WORD_W-1:0] main_base,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);
  logic [M_W-1:0]   m_off;
  logic [N_W-1:0]   n_off;
  logic [CFG_W-1:0] cfg_off;
  logic [CFG_W+1:0] cfg_x4;

  always_comb begin
    m_off   = m - M_W'(2);
    n_off   = n - N_W'(1);
    cfg_off = cfg_mhz - CFG_W'(CFG_BASE_MHZ);
    cfg_x4  = {cfg_off, 2'b00};

    main_base = '0;
    main_base[CSEL_LSB +: 2]        = CSEL_GEN;
    main_base[CFGR_LSB +: CFGR_W]   = cfg_x4[CFGR_W-1:0];
    main_base[HSR_LSB +: HSR_W]     = hsr;

    word0 = '0;
    word0[0 +: MOFF_W]         = m_off[MOFF_W-1:0];
    word0[NOFF_LSB +: NOFF_W]  = n_off[NOFF_W-1:0];
    word0[VCO_LSB +: VCO_W]    = vco;
    word0[PROP_LSB +: PROP_W]  = prop;

    word1 = '0;
    word1[1:0]           = GMP_VAL;
    word1[BIAS_LSB +: 7] = BIAS_VAL;
  end
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int STEP_CYC   = 100,
  parameter int SETTLE_CYC = 1000,
  parameter int UPD_CYC    = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [10:0]       m_i,
  input  logic [4:0]        n_i,
  input  logic [5:0]        vco_i,
  input  logic [5:0]        prop_i,
  input  logic [6:0]        hsr_i,
  input  logic [7:0]        cfg_mhz_i,
  output logic [31:0]       ctrl_main_o,
  output logic [31:0]       ctrl_w0_o,
  output logic [31:0]       ctrl_w1_o,
  output logic              ref_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WAIT_MAX = (STEP_CYC > SETTLE_CYC)
                          ? ((STEP_CYC > UPD_CYC) ? STEP_CYC : UPD_CYC)
                          : ((SETTLE_CYC > UPD_CYC) ? SETTLE_CYC : UPD_CYC);
  localparam int CW = $clog2(WAIT_MAX + 1) + 1;

  seq_state_t state_q;

  logic [M_W-1:0]    cap_m_q;
  logic [N_W-1:0]    cap_n_q;
  logic [VCO_W-1:0]  cap_vco_q;
  logic [PROP_W-1:0] cap_prop_q;
  logic [HSR_W-1:0]  cap_hsr_q;
  logic [CFG_W-1:0]  cap_cfg_q;

  logic [WORD_W-1:0] main_q, w0_q, w1_q;
  logic              ref_en_q, busy_q, done_q;

  logic [WORD_W-1:0] main_base, word0, word1;
  logic              tmr_load, tmr_exp;
  logic [CW-1:0]     tmr_val;
  logic              go;

  assign go = start_i && (state_q == ST_IDLE) && !stop_i;

  pll_word_pack u_pack (
    .m         (cap_m_q),
    .n         (cap_n_q),
    .vco       (cap_vco_q),
    .prop      (cap_prop_q),
    .hsr       (cap_hsr_q),
    .cfg_mhz   (cap_cfg_q),
    .main_base (main_base),
    .word0     (word0),
    .word1     (word1)
  );

  pll_wait_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:   if (go)      begin tmr_load = 1'b1; tmr_val = CW'(STEP_CYC - 1); end
      ST_CSEL:   if (tmr_exp) begin tmr_load = 1'b1; tmr_val = CW'(STEP_CYC - 1); end
      ST_SHCLR:  if (tmr_exp) begin tmr_load = 1'b1; tmr_val = CW'(STEP_CYC - 1); end
      ST_LOAD:   begin tmr_load = 1'b1; tmr_val = CW'(SETTLE_CYC - 1); end
      ST_SETTLE: if (tmr_exp) begin tmr_load = 1'b1; tmr_val = CW'(UPD_CYC - 1); end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_m_q <= '0; cap_n_q <= '0; cap_vco_q <= '0;
      cap_prop_q <= '0; cap_hsr_q <= '0; cap_cfg_q <= '0;
    end else if (go) begin
      cap_m_q    <= m_i;
      cap_n_q    <= n_i;
      cap_vco_q  <= vco_i;
      cap_prop_q <= prop_i;
      cap_hsr_q  <= hsr_i;
      cap_cfg_q  <= cfg_mhz_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stop_i) begin
      state_q  <= ST_IDLE;
      main_q   <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      ref_en_q <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (go) begin
          main_q <= '0;
          main_q[CSEL_LSB +: 2] <= CSEL_GEN;
          busy_q  <= 1'b1;
          state_q <= ST_CSEL;
        end
        ST_CSEL: if (tmr_exp) begin
          main_q[SHCLR_BIT] <= 1'b1;
          state_q <= ST_SHCLR;
        end
        ST_SHCLR: if (tmr_exp) begin
          main_q[SHCLR_BIT] <= 1'b0;
          state_q <= ST_REL;
        end
        ST_REL: if (tmr_exp) begin
          main_q  <= main_base;
          w0_q    <= word0;
          w1_q    <= word1;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          ref_en_q <= 1'b1;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (tmr_exp) begin
          main_q[UPD_BIT] <= 1'b1;
          state_q <= ST_UPD;
        end
        ST_UPD: if (tmr_exp) begin
          main_q[UPD_BIT] <= 1'b0;
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_main_o = main_q;
  assign ctrl_w0_o   = w0_q;
  assign ctrl_w1_o   = w1_q;
  assign ref_en_o    = ref_en_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;

  // update-pulse width monitor
  logic [CW-1:0] upd_run_q;
  always_ff @(posedge clk) begin
    if (rst) upd_run_q <= '0;
    else if (main_q[UPD_BIT]) upd_run_q <= upd_run_q + 1'b1;
    else upd_run_q <= '0;
  end

  // R8
  upd_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(main_q[UPD_BIT]) && !$past(stop_i)) |-> (upd_run_q == CW'(UPD_CYC)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  upd_needs_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(main_q[UPD_BIT]) |-> ref_en_q);

  // R3
  shclr_with_csel_chk: assert property (@(posedge clk) disable iff (rst)
    main_q[SHCLR_BIT] |-> (main_q[CSEL_LSB +: 2] == CSEL_GEN));

  // R2
  start_word_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (ctrl_main_o == 32'h40));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start_i && !stop_i) |=> ($stable(cap_m_q) && $stable(cap_hsr_q)));

  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (main_q == '0 && w0_q == '0 && w1_q == '0 && !ref_en_q && !busy_q));
endmodule

// File: tb/pll_prog_seq_bench.sv
module pll_prog_seq_bench;
  localparam int STEP = 2;
  localparam int SETL = 10;
  localparam int UPD  = 4;
  localparam int LEN  = 3*STEP + 1 + SETL + UPD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, stop_i = 1'b0;
  logic [10:0] m_i = '0;
  logic [4:0]  n_i = '0;
  logic [5:0]  vco_i = '0, prop_i = '0;
  logic [6:0]  hsr_i = '0;
  logic [7:0]  cfg_mhz_i = '0;
  logic [31:0] ctrl_main_o, ctrl_w0_o, ctrl_w1_o;
  logic        ref_en_o, busy_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pll_prog_seq #(.STEP_CYC(STEP), .SETTLE_CYC(SETL), .UPD_CYC(UPD)) u_pll_prog_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .m_i(m_i), .n_i(n_i), .vco_i(vco_i), .prop_i(prop_i),
    .hsr_i(hsr_i), .cfg_mhz_i(cfg_mhz_i),
    .ctrl_main_o(ctrl_main_o), .ctrl_w0_o(ctrl_w0_o), .ctrl_w1_o(ctrl_w1_o),
    .ref_en_o(ref_en_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=0x%08h expected=0x%08h", req, $time, act, exp);
    end
  endtask

  task automatic check_zero(input string req);
    chk(req, ctrl_main_o, 32'h0);
    chk(req, ctrl_w0_o, 32'h0);
    chk(req, ctrl_w1_o, 32'h0);
    chk(req, {31'b0, ref_en_o}, 32'h0);
    chk(req, {31'b0, busy_o}, 32'h0);
    chk(req, {31'b0, done_o}, 32'h0);
  endtask

  // caller is just after a negedge
  task automatic do_stop(input bit with_start);
    stop_i = 1'b1; start_i = with_start;
    @(posedge clk); @(negedge clk);
    stop_i = 1'b0; start_i = 1'b0;
    check_zero(with_start ? "R10 stop beats start" : "R10 stop");
  endtask

  task automatic run_seq(input int m, input int n, input int vco, input int prop,
                         input int hs, input int cfg, input int stop_at, input bit poke);
    logic [31:0] base, w0, w1, em;
    base = 32'h40 | (((cfg - 17) * 4) & 63) | ((hs & 127) << 8);
    w0 = ((m - 2) & 1023) | (((n - 1) & 15) << 10) | ((vco & 63) << 14) | ((prop & 63) << 20);
    w1 = 32'h41;
    m_i = 11'(m); n_i = 5'(n); vco_i = 6'(vco); prop_i = 6'(prop);
    hsr_i = 7'(hs); cfg_mhz_i = 8'(cfg);
    start_i = 1'b1;
    for (int k = 0; k <= LEN + 3; k++) begin
      @(posedge clk); @(negedge clk);
      start_i = 1'b0;
      if (k < STEP) em = 32'h40;                                   // R2
      else if (k < 2*STEP) em = 32'h40 | (32'h1 << 18);            // R3
      else if (k < 3*STEP) em = 32'h40;                            // R3
      else if (k >= 3*STEP + 1 + SETL && k < LEN) em = base | (32'h1 << 17); // R7
      else em = base;                                              // R4, R11
      chk(k < 3*STEP ? "R2/R3 main word" : "R4/R7/R11 main word", ctrl_main_o, em);
      chk("R5 word0", ctrl_w0_o, (k >= 3*STEP) ? w0 : 32'h0);
      chk("R6 word1", ctrl_w1_o, (k >= 3*STEP) ? w1 : 32'h0);
      chk("R7 ref enable", {31'b0, ref_en_o}, (k >= 3*STEP + 1) ? 32'h1 : 32'h0);
      chk("R8 busy", {31'b0, busy_o}, (k < LEN) ? 32'h1 : 32'h0);
      chk("R8 done", {31'b0, done_o}, (k == LEN) ? 32'h1 : 32'h0);
      if (poke && k == 3) begin
        // R9: a second start with other values while busy
        m_i = 11'(m + 5); n_i = 5'(n + 1); hsr_i = 7'(hs + 3); cfg_mhz_i = 8'(cfg + 1);
        vco_i = 6'(vco + 1); prop_i = 6'(prop + 1);
        start_i = 1'b1;
      end
      if (k == stop_at) begin
        do_stop(1'b0);
        @(posedge clk); @(negedge clk);
        check_zero("R10 stays cleared");
        return;
      end
    end
    do_stop(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_zero("R1 reset state");
    // sweep of settings, including offset wrap limits
    for (int i = 0; i < 16; i++) begin
      run_seq((i == 15) ? 1025 : 2 + i*41, 1 + i, (i*4 + 3) & 63, 63 - i*3,
              (i*9) & 127, 17 + i, -1, (i % 3) == 1);
    end
    // stop at every cycle of the sequence
    for (int s = 0; s < LEN + 1; s++) begin
      run_seq(100 + s, 1 + (s % 16), s, 2*s, s + 40, 20 + (s % 8), s, 1'b0);
    end
    // stop and start together while idle
    do_stop(1'b1);
    @(posedge clk); @(negedge clk);
    check_zero("R10 start ignored under stop");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule